// File: doc/BRIEF.md
# Phase-Locked Loop Unlock Detector with Stretched Flag

This block watches a phase-locked loop from outside. It takes the reference phase pulse and the divided feedback phase pulse, brings each into the sampling clock domain and finds their rising edges. Whenever one edge arrives without the other, it opens an error window. The window stays open until the other input's edge arrives, and its length is counted in sampling-clock cycles. The result drives a single active-low unlock flag whose behaviour depends on a two-bit mode field.

Each mode sets the output differently:

- Mode `00` turns detection off and holds the flag released (high).
- Mode `01` passes the raw error window straight to the flag.
- Mode `10` flags an unlock only when a window lasts longer than a short threshold.
- Mode `11` does the same against a longer threshold.

In the two threshold modes the flag stays low for a programmable stretch time after the last cycle of excessive error. This keeps brief slips visible to slow logic, which would otherwise miss them. The thresholds and the stretch length are parameters given in clock cycles. At a 200 MHz clock, the defaults correspond to 0.5 µs, 1.0 µs and 2 ms.

Top module: `pll_unlock_mon`

## Requirements
- R1: After synchronous reset, `unlock_n` is 1 and no error window is open.
- R2: With `mode` = 2'b00, `unlock_n` is 1 one cycle later and stays 1 whatever the phase inputs do.
- R3: With `mode` = 2'b01, a gap of D cycles between the two rising edges drives `unlock_n` low for exactly D cycles. The output lags the leading input edge by four clock edges: two synchroniser flops, the edge flop and the output register.
- R4: With `mode` = 2'b10, a gap of D ≤ NARROW_CYC cycles leaves `unlock_n` high. A gap of D > NARROW_CYC cycles drives it low.
- R5: With `mode` = 2'b11, the same rule applies with WIDE_CYC as the limit.
- R6: In modes 2'b10 and 2'b11, a single excessive gap of D cycles against limit T keeps `unlock_n` low for exactly (D − T) + STRETCH_CYC consecutive cycles.
- R7: A new excessive error that arrives while the flag is still stretched reloads the stretch time, so the flag is released STRETCH_CYC cycles after the last excessive cycle.
- R8: Rising edges seen in the same sampled cycle on both inputs open no window, and `unlock_n` stays high.
- R9: Any change of `mode` clears the stretch timer and closes the open window. With no new error, `unlock_n` is high two cycles after the change.
- R10: Either input may lead. A window opened by the feedback edge is closed by the reference edge, and is measured the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Detection mode: 00 off, 01 raw, 10 narrow limit, 11 wide limit |
| ref_pulse | input | 1 | Reference phase pulse, asynchronous |
| fb_pulse | input | 1 | Divided feedback phase pulse, asynchronous |
| unlock_n | output | 1 | Active-low unlock flag, registered |

## Verification
Edge pairs are driven with gaps exactly at each threshold and one cycle above it. This separates a strict "exceeds" comparison from an inclusive one. It also shows which limit each mode selects.

Several further patterns are used:
- Leads by either input show that the window closes on the other input's edge, not its own.
- Simultaneous edges show that a zero-length gap is ignored.
- Raw-mode gaps of different lengths pin down the pass-through latency.
- A second error during a stretch, and a mode switch during a stretch, tell a reloading, clearable timer apart from a one-shot one.

// File: rtl/pll_unlock_pkg.sv
package pll_unlock_pkg;

  typedef enum logic [1:0] {
    DET_OFF    = 2'b00,
    DET_RAW    = 2'b01,
    DET_NARROW = 2'b10,
    DET_WIDE   = 2'b11
  } det_mode_e;

  localparam int NUM_PH = 2;
  localparam int PH_REF = 0;
  localparam int PH_FB  = 1;

  function automatic logic is_limit_mode(det_mode_e m);
    return (m == DET_NARROW) || (m == DET_WIDE);
  endfunction

endpackage

// File: rtl/phase_edge_sync.sv
module phase_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else begin
      sh <= {sh[SH_W-2:0], din};
    end
  end

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/phase_err_meter.sv
module phase_err_meter
  import pll_unlock_pkg::*;
#(
  parameter int NARROW_CYC = 100,
  parameter int WIDE_CYC   = 200
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  det_mode_e mode,
  input  logic      ref_rise,
  input  logic      fb_rise,
  output logic      win,
  output logic      over
);
  localparam int CNT_MAX = WIDE_CYC + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] THR_N   = CNT_W'(NARROW_CYC);
  localparam logic [CNT_W-1:0] THR_W   = CNT_W'(WIDE_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt;
  logic             lead_ref;
  logic             closer;
  logic [CNT_W-1:0] thr;

  assign closer = lead_ref ? fb_rise : ref_rise;
  assign thr    = (mode == DET_WIDE) ? THR_W : THR_N;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win      <= 1'b0;
      lead_ref <= 1'b0;
      cnt      <= '0;
    end else if (!win) begin
      if (ref_rise ^ fb_rise) begin
        win      <= 1'b1;
        lead_ref <= ref_rise;
        cnt      <= '0;
      end
    end else if (closer) begin
      win <= 1'b0;
      cnt <= '0;
    end else if (cnt != CNT_TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign over = win && is_limit_mode(mode) && (cnt >= thr);
endmodule

// File: rtl/unlock_stretch.sv
module unlock_stretch #(
  parameter int STRETCH_CYC = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic trig,
  output logic hold
);
  localparam int TMR_W = $clog2(STRETCH_CYC + 1);
  localparam logic [TMR_W-1:0] LOAD = TMR_W'(STRETCH_CYC);

  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tmr <= '0;
    end else if (trig) begin
      tmr <= LOAD;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign hold = (tmr != '0);
endmodule

// File: rtl/pll_unlock_mon.sv
module pll_unlock_mon
  import pll_unlock_pkg::*;
#(
  parameter int NARROW_CYC  = 100,
  parameter int WIDE_CYC    = 200,
  parameter int STRETCH_CYC = 400000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       ref_pulse,
  input  logic       fb_pulse,
  output logic       unlock_n
);
  det_mode_e          mode_e;
  det_mode_e          mode_q;
  logic               chg;
  logic               clear;
  logic [NUM_PH-1:0]  ph_in;
  logic [NUM_PH-1:0]  ph_rise;
  logic               win;
  logic               over;
  logic               hold;

  assign mode_e = det_mode_e'(mode);
  assign ph_in  = {fb_pulse, ref_pulse};

  for (genvar g = 0; g < NUM_PH; g++) begin : g_sync
    phase_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (ph_in[g]),
      .rise (ph_rise[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= DET_OFF;
    else     mode_q <= mode_e;
  end

  assign chg   = (mode_e != mode_q);
  assign clear = chg || (mode_e == DET_OFF);

  phase_err_meter #(
    .NARROW_CYC (NARROW_CYC),
    .WIDE_CYC   (WIDE_CYC)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .mode     (mode_e),
    .ref_rise (ph_rise[PH_REF]),
    .fb_rise  (ph_rise[PH_FB]),
    .win      (win),
    .over     (over)
  );

  unlock_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk   (clk),
    .rst   (rst),
    .clear (chg),
    .trig  (over),
    .hold  (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_n <= 1'b1;
    end else begin
      unique case (mode_e)
        DET_OFF: unlock_n <= 1'b1;
        DET_RAW: unlock_n <= ~win;
        default: unlock_n <= ~(over | hold);
      endcase
    end
  end
endmodule

// File: rtl/pll_unlock_chk.sv
module pll_unlock_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       unlock_n,
  input logic       win,
  input logic       over,
  input logic       hold,
  input logic       chg
);
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> unlock_n);                          // R2
  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && win) |=> !unlock_n);                  // R3
  AST_STRETCH_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && hold) |=> !unlock_n);                       // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (over && !chg) |=> hold);                               // R7
  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    chg |=> (!hold && !win));                               // R9
endmodule

bind pll_unlock_mon pll_unlock_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .unlock_n (unlock_n),
  .win      (win),
  .over     (over),
  .hold     (hold),
  .chg      (chg)
);

// File: tb/tb_pll_unlock_mon.sv
module tb_pll_unlock_mon;
  localparam int NARROW = 12;
  localparam int WIDE   = 24;
  localparam int STR    = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       ref_pulse = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       unlock_n;

  int checks = 0;
  int fails = 0;
  int low_cnt = 0;
  string cur_req = "R1";

  pll_unlock_mon #(
    .NARROW_CYC (NARROW),
    .WIDE_CYC   (WIDE),
    .STRETCH_CYC(STR)
  ) dut (
    .clk(clk), .rst(rst), .mode(mode),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .unlock_n(unlock_n)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit rq[$];
  bit fq[$];
  bit m_win = 0, m_lead_ref = 0, exp_n = 1;
  int m_cnt = 0, m_tmr = 0;
  logic [1:0] m_mode_q = 2'b00;

  function automatic int limit_of(logic [1:0] m);
    return (m == 2'b11) ? WIDE : NARROW;
  endfunction

  initial begin
    rq = '{0, 0, 0};
    fq = '{0, 0, 0};
  end

  always @(posedge clk) begin
    if (rst) begin
      rq = '{0, 0, 0};
      fq = '{0, 0, 0};
      m_win = 0; m_cnt = 0; m_tmr = 0; m_mode_q = 2'b00; exp_n = 1;
    end else begin
      bit re, fe, chg, ovr;
      re  = rq[1] && !rq[2];
      fe  = fq[1] && !fq[2];
      chg = (mode != m_mode_q);
      ovr = m_win && mode[1] && (m_cnt >= limit_of(mode));
      case (mode)
        2'b00:   exp_n = 1;
        2'b01:   exp_n = !m_win;
        default: exp_n = !(ovr || m_tmr != 0);
      endcase
      if (chg) m_tmr = 0;
      else if (ovr) m_tmr = STR;
      else if (m_tmr > 0) m_tmr = m_tmr - 1;
      if (chg || mode == 2'b00) begin
        m_win = 0; m_cnt = 0;
      end else if (!m_win) begin
        if (re != fe) begin
          m_win = 1; m_lead_ref = re; m_cnt = 0;
        end
      end else if (m_lead_ref ? fe : re) begin
        m_win = 0; m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_mode_q = mode;
      rq.push_front(ref_pulse); void'(rq.pop_back());
      fq.push_front(fb_pulse);  void'(fq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (unlock_n !== exp_n) begin
        fails++;
        $display("FAIL %s: cycle compare unlock_n=%0b expected %0b", cur_req, unlock_n, exp_n);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    if (!unlock_n) low_cnt++;
  endtask

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic gap(bit lead_ref, int d);
    low_cnt = 0;
    if (lead_ref) ref_pulse = 1; else fb_pulse = 1;
    for (int i = 0; i < d; i++) step();
    if (lead_ref) fb_pulse = 1; else ref_pulse = 1;
    for (int i = 0; i < 4; i++) step();
    ref_pulse = 0; fb_pulse = 0;
    for (int i = 0; i < d + STR + 20; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R1", unlock_n, 1, "unlock_n in reset");
    rst = 0;
    step();
    check("R1", unlock_n, 1, "unlock_n after reset");

    cur_req = "R2"; mode = 2'b00; step();
    gap(1, 40);  check("R2", low_cnt, 0, "low cycles, detection off");

    cur_req = "R3"; mode = 2'b01; for (int i = 0; i < 3; i++) step();
    gap(1, 7);   check("R3", low_cnt, 7, "raw low cycles, gap 7");
    gap(1, 30);  check("R3", low_cnt, 30, "raw low cycles, gap 30");
    cur_req = "R10";
    gap(0, 5);   check("R10", low_cnt, 5, "raw low cycles, feedback leads by 5");
    cur_req = "R8";
    gap(1, 0);   check("R8", low_cnt, 0, "low cycles, simultaneous edges");

    cur_req = "R4"; mode = 2'b10; for (int i = 0; i < 3; i++) step();
    gap(1, NARROW);     check("R4", low_cnt, 0, "gap equal to narrow limit");
    gap(1, NARROW + 1); check("R6", low_cnt, 1 + STR, "stretched low, gap narrow+1");
    cur_req = "R10";
    gap(0, 20);         check("R10", low_cnt, 20 - NARROW + STR, "feedback leads by 20, narrow");

    cur_req = "R5"; mode = 2'b11; for (int i = 0; i < 3; i++) step();
    gap(1, NARROW + 1); check("R5", low_cnt, 0, "narrow+1 gap under wide limit");
    gap(1, WIDE);       check("R5", low_cnt, 0, "gap equal to wide limit");
    gap(1, WIDE + 1);   check("R5", low_cnt, 1 + STR, "stretched low, gap wide+1");

    // R7: a second error during the stretch extends it
    cur_req = "R7"; mode = 2'b10; for (int i = 0; i < 3; i++) step();
    low_cnt = 0;
    ref_pulse = 1; for (int i = 0; i < NARROW + 2; i++) step();
    fb_pulse = 1;  for (int i = 0; i < 4; i++) step();
    ref_pulse = 0; fb_pulse = 0; for (int i = 0; i < 20; i++) step();
    ref_pulse = 1; for (int i = 0; i < NARROW + 2; i++) step();
    fb_pulse = 1;  for (int i = 0; i < 4; i++) step();
    ref_pulse = 0; fb_pulse = 0;
    for (int i = 0; i < STR + 40; i++) step();
    // first over starts at leader+12 offset; second ends 2+ (14+4+20+... ) later
    check("R7", low_cnt, (NARROW + 2 + 4 + 20 + NARROW + 2) - NARROW + STR,
          "contiguous low span over two errors");

    // R9: mode change releases a stretched flag
    cur_req = "R9";
    ref_pulse = 1; for (int i = 0; i < NARROW + 5; i++) step();
    fb_pulse = 1;  for (int i = 0; i < 6; i++) step();
    ref_pulse = 0; fb_pulse = 0;
    check("R9", unlock_n, 0, "flag low before mode change");
    mode = 2'b11;
    step(); step();
    check("R9", unlock_n, 1, "flag two cycles after mode change");
    for (int i = 0; i < 10; i++) step();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule